// File: doc/BRIEF.md
# Pin Function Multiplexer

This block decides, pin by pin, which peripheral function drives each device pin and which pin feeds each peripheral's input. Every pin owns a 32-bit configuration word, written and read through a simple register port addressed by pin number. The word holds an 8-bit function selector and two pull-resistor controls that go straight to the pad cell. A static table, passed in as a parameter, lists for every pin which function index each selector value picks. Selector 0 always leaves the pin tri-stated, and that is the reset state.

Output data and output enable of the chosen function are steered to the pin. In the other direction, each function's input comes from the pin that currently selects it. If several pins select the same function, the lowest-numbered one wins. A function that no pin selects gets one of two things. If it is flagged as having a deselected state, it receives a fixed constant. Otherwise it receives the input of the lowest pin whose table can reach it, so a pin's input is shared with every peripheral on that pin whatever the selector holds. A selector value with no function behind it is illegal: the pin stays tri-stated and a per-pin error flag latches.

Register writes land on the next rising clock edge. All steering is combinational from the registered words. Reset is synchronous and active-high. The block has no state machine, and its only sequential state is the configuration words and the error flags.

Top module: `pinmux_ctrl`

## Requirements
- R1: After reset, every in-range pin word reads 0x000C0000, every `pad_oe` bit is 0, every `pad_pull_en` bit is 1, every `pad_pull_up` bit is 0 and `mode_err` is 0.
- R2: A write with `reg_we` high to an in-range `reg_addr` stores `reg_wdata[7:0]` as that pin's selector. It is visible on `reg_rdata[7:0]` after the next rising edge and not before.
- R3: Read data bits [31:20] and [15:8] are always 0, and bits [19:18] always read 1 for an in-range address, whatever was written.
- R4: Word bit 16 is a pull disable, so `pad_pull_en` is its inverse. Word bit 17 selects the pull direction, with 1 meaning pull-up, and `pad_pull_up` equals it. Both bits read back.
- R5: A pin whose selector is 0 has `pad_oe` and `pad_out` at 0.
- R6: A pin whose selector maps to function f drives `pad_out`/`pad_oe` from `func_out[f]`/`func_oe[f]`. The default table is: pin0 modes 1,2,3 map to f0,f1,f4; pin1 maps to f1,f2 with mode 3 empty; pin2 maps to f2,f3,f5; pin3 maps to f3,f0,f6.
- R7: A nonzero selector that is beyond the table or hits an empty entry keeps the pin tri-stated. One cycle after the word is stored, it sets that pin's `mode_err` bit, which then stays set until reset.
- R8: A function selected by one or more pins takes `func_in` from the lowest-numbered such pin.
- R9: A function with a deselected state that no pin selects gets its constant on `func_in`. The defaults are f2 at 1, f5 at 0 and f7 at 1.
- R10: A function without a deselected state that no pin selects gets the input of the lowest pin whose table contains it. By default that pin is pin0 for f0, f1 and f4, pin2 for f3 and pin3 for f6.
- R11: A write to an address at or above the pin count changes no word, and a read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Pin number of the word accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed word, combinational |
| func_out | input | NUM_FUNCS | Output data from each peripheral function |
| func_oe | input | NUM_FUNCS | Output enable from each peripheral function |
| func_in | output | NUM_FUNCS | Input value delivered to each peripheral function |
| pad_in | input | NUM_PINS | Value seen at each pin |
| pad_out | output | NUM_PINS | Data to each pin buffer |
| pad_oe | output | NUM_PINS | Output enable of each pin buffer |
| pad_pull_en | output | NUM_PINS | Pull resistor enable per pin |
| pad_pull_up | output | NUM_PINS | Pull direction per pin, 1 for pull-up |
| mode_err | output | NUM_PINS | Sticky illegal-selector flag per pin |

## Verification
Two functions can act in the same cycle. A register write can move a function from one pin to another while a second pin already selects that function. Input arbitration and output steering then have to settle together from the newly stored word. The bench provokes this by having two pins select the same function with opposite pad values, and then by releasing the lower pin. After each stored write it judges `func_in` against the lowest-pin rule. A write of an illegal selector is checked in the same way: on the cycle after storage the pin must already be tri-stated, and the error flag must follow one edge later and outlive a legal rewrite.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
    localparam int WORD_W     = 32;
    localparam int SEL_W      = 8;
    localparam int PULL_UP_B  = 17;
    localparam int PULL_DIS_B = 16;

    typedef struct packed {
        logic             pull_up;
        logic             pull_dis;
        logic [SEL_W-1:0] sel;
    } pin_cfg_t;
endpackage

// File: rtl/pinmux_regs.sv
module pinmux_regs
    import pinmux_pkg::*;
#(
    parameter int NUM_PINS = 4,
    parameter int ADDR_W   = 3
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            we,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [WORD_W-1:0]               wdata,
    output logic [WORD_W-1:0]               rdata,
    input  logic [NUM_PINS-1:0]             illegal,
    output pin_cfg_t [NUM_PINS-1:0]         cfg,
    output logic [NUM_PINS-1:0]             err
);
    localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    pin_cfg_t [NUM_PINS-1:0] cfg_q;
    logic     [NUM_PINS-1:0] err_q;
    logic                    addr_ok;
    logic     [IDX_W-1:0]    idx;

    assign addr_ok = (32'(addr) < NUM_PINS);
    assign idx     = addr[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            err_q <= '0;
        end else begin
            if (we && addr_ok) begin
                cfg_q[idx] <= '{pull_up:  wdata[PULL_UP_B],
                                pull_dis: wdata[PULL_DIS_B],
                                sel:      wdata[SEL_W-1:0]};
            end
            err_q <= err_q | illegal;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr_ok) begin
            rdata[19:18]      = 2'b11;
            rdata[PULL_UP_B]  = cfg_q[idx].pull_up;
            rdata[PULL_DIS_B] = cfg_q[idx].pull_dis;
            rdata[SEL_W-1:0]  = cfg_q[idx].sel;
        end
    end

    assign cfg = cfg_q;
    assign err = err_q;
endmodule

// File: rtl/pinmux_out_sel.sv
module pinmux_out_sel
    import pinmux_pkg::*;
#(
    parameter int NUM_PINS  = 4,
    parameter int NUM_FUNCS = 8,
    parameter int NUM_MODES = 4,
    parameter int FW        = 4,
    parameter logic [NUM_PINS*NUM_MODES*FW-1:0] MAP = '1
) (
    input  logic [NUM_PINS-1:0][SEL_W-1:0] pin_sel,
    input  logic [NUM_FUNCS-1:0]           func_out,
    input  logic [NUM_FUNCS-1:0]           func_oe,
    output logic [NUM_PINS-1:0]            pad_out,
    output logic [NUM_PINS-1:0]            pad_oe,
    output logic [NUM_PINS-1:0]            sel_valid,
    output logic [NUM_PINS-1:0][FW-1:0]    sel_func,
    output logic [NUM_PINS-1:0]            illegal
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic [FW-1:0] entry;
        logic          in_table;
        logic          valid;
        logic          drv;
        logic          en;

        always_comb begin
            in_table = (pin_sel[p] != '0) && (32'(pin_sel[p]) < NUM_MODES);
            entry    = '1;
            if (in_table) begin
                entry = MAP[(p*NUM_MODES + 32'(pin_sel[p]))*FW +: FW];
            end
            valid = in_table && (32'(entry) < NUM_FUNCS);
        end

        always_comb begin
            drv = 1'b0;
            en  = 1'b0;
            for (int f = 0; f < NUM_FUNCS; f++) begin
                if (valid && (32'(entry) == f)) begin
                    drv = func_out[f];
                    en  = func_oe[f];
                end
            end
        end

        assign pad_out[p]   = drv;
        assign pad_oe[p]    = en;
        assign sel_valid[p] = valid;
        assign sel_func[p]  = entry;
        assign illegal[p]   = (pin_sel[p] != '0) && !valid;
    end
endmodule

// File: rtl/pinmux_in_route.sv
module pinmux_in_route #(
    parameter int NUM_PINS  = 4,
    parameter int NUM_FUNCS = 8,
    parameter int NUM_MODES = 4,
    parameter int FW        = 4,
    parameter logic [NUM_PINS*NUM_MODES*FW-1:0] MAP = '1,
    parameter logic [NUM_FUNCS-1:0] DSIS_EN  = '0,
    parameter logic [NUM_FUNCS-1:0] DSIS_VAL = '0
) (
    input  logic [NUM_PINS-1:0]         pad_in,
    input  logic [NUM_PINS-1:0]         sel_valid,
    input  logic [NUM_PINS-1:0][FW-1:0] sel_func,
    output logic [NUM_FUNCS-1:0]        func_in
);
    function automatic int home_pin(int f);
        int h;
        h = -1;
        for (int p = NUM_PINS - 1; p >= 0; p--) begin
            for (int m = 1; m < NUM_MODES; m++) begin
                if (32'(MAP[(p*NUM_MODES + m)*FW +: FW]) == f) h = p;
            end
        end
        return h;
    endfunction

    for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_func
        localparam int HOME = home_pin(f);
        logic shared;
        logic v;

        if (HOME >= 0) begin : g_home
            assign shared = pad_in[HOME];
        end else begin : g_nohome
            assign shared = 1'b0;
        end

        always_comb begin
            v = DSIS_EN[f] ? DSIS_VAL[f] : shared;
            for (int p = NUM_PINS - 1; p >= 0; p--) begin
                if (sel_valid[p] && (32'(sel_func[p]) == f)) v = pad_in[p];
            end
        end

        assign func_in[f] = v;
    end
endmodule

// File: rtl/pinmux_ctrl.sv
module pinmux_ctrl
    import pinmux_pkg::*;
#(
    parameter int NUM_PINS   = 4,
    parameter int NUM_FUNCS  = 8,
    parameter int NUM_MODES  = 4,
    parameter int FUNC_IDX_W = 4,
    parameter int ADDR_W     = 3,
    parameter logic [NUM_PINS*NUM_MODES*FUNC_IDX_W-1:0] MAP = 64'h603F_532F_F21F_410F,
    parameter logic [NUM_FUNCS-1:0] DSIS_EN  = 8'hA4,
    parameter logic [NUM_FUNCS-1:0] DSIS_VAL = 8'h84
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [NUM_FUNCS-1:0] func_out,
    input  logic [NUM_FUNCS-1:0] func_oe,
    output logic [NUM_FUNCS-1:0] func_in,
    input  logic [NUM_PINS-1:0]  pad_in,
    output logic [NUM_PINS-1:0]  pad_out,
    output logic [NUM_PINS-1:0]  pad_oe,
    output logic [NUM_PINS-1:0]  pad_pull_en,
    output logic [NUM_PINS-1:0]  pad_pull_up,
    output logic [NUM_PINS-1:0]  mode_err
);
    pin_cfg_t [NUM_PINS-1:0]                 cfg;
    logic     [NUM_PINS-1:0][SEL_W-1:0]      pin_sel;
    logic     [NUM_PINS-1:0]                 sel_valid;
    logic     [NUM_PINS-1:0][FUNC_IDX_W-1:0] sel_func;
    logic     [NUM_PINS-1:0]                 illegal;

    pinmux_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .illegal(illegal),
        .cfg(cfg), .err(mode_err)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
        assign pin_sel[p]     = cfg[p].sel;
        assign pad_pull_en[p] = ~cfg[p].pull_dis;
        assign pad_pull_up[p] = cfg[p].pull_up;
    end

    pinmux_out_sel #(
        .NUM_PINS(NUM_PINS), .NUM_FUNCS(NUM_FUNCS), .NUM_MODES(NUM_MODES),
        .FW(FUNC_IDX_W), .MAP(MAP)
    ) out_i (
        .pin_sel(pin_sel), .func_out(func_out), .func_oe(func_oe),
        .pad_out(pad_out), .pad_oe(pad_oe), .sel_valid(sel_valid),
        .sel_func(sel_func), .illegal(illegal)
    );

    pinmux_in_route #(
        .NUM_PINS(NUM_PINS), .NUM_FUNCS(NUM_FUNCS), .NUM_MODES(NUM_MODES),
        .FW(FUNC_IDX_W), .MAP(MAP), .DSIS_EN(DSIS_EN), .DSIS_VAL(DSIS_VAL)
    ) in_i (
        .pad_in(pad_in), .sel_valid(sel_valid), .sel_func(sel_func),
        .func_in(func_in)
    );
endmodule

// File: rtl/pinmux_ctrl_chk.sv
module pinmux_ctrl_chk #(
    parameter int NUM_PINS = 4,
    parameter int ADDR_W   = 3
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      reg_we,
    input logic [ADDR_W-1:0]         reg_addr,
    input logic [31:0]               reg_wdata,
    input logic [31:0]               reg_rdata,
    input logic [NUM_PINS-1:0][7:0]  pin_sel,
    input logic [NUM_PINS-1:0]       pad_oe,
    input logic [NUM_PINS-1:0]       mode_err
);
    localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    // R3
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[31:20] == 12'h0) && (reg_rdata[15:8] == 8'h0));

    // R3
    rsvd_one_chk: assert property (@(posedge clk) disable iff (rst)
        (32'(reg_addr) < NUM_PINS) |-> (reg_rdata[19:18] == 2'b11));

    // R11
    oor_read_chk: assert property (@(posedge clk) disable iff (rst)
        (32'(reg_addr) >= NUM_PINS) |-> (reg_rdata == 32'h0));

    // R2
    sel_store_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && (32'(reg_addr) < NUM_PINS)) |=>
        (pin_sel[$past(reg_addr[IDX_W-1:0])] == $past(reg_wdata[7:0])));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_err != '0) |=> ((mode_err & $past(mode_err)) == $past(mode_err)));

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        // R5
        idle_tristate_chk: assert property (@(posedge clk) disable iff (rst)
            (pin_sel[p] == 8'h0) |-> !pad_oe[p]);
    end
endmodule

bind pinmux_ctrl pinmux_ctrl_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_sel(pin_sel),
    .pad_oe(pad_oe), .mode_err(mode_err)
);

// File: tb/pinmux_ctrl_tb_top.sv
module pinmux_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  func_out = '0;
    logic [7:0]  func_oe = '0;
    logic [7:0]  func_in;
    logic [3:0]  pad_in = 4'b0101;
    logic [3:0]  pad_out, pad_oe, pad_pull_en, pad_pull_up, mode_err;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pinmux_ctrl dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .func_out(func_out),
        .func_oe(func_oe), .func_in(func_in), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_en(pad_pull_en),
        .pad_pull_up(pad_pull_up), .mode_err(mode_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int p = 0; p < 4; p++) begin
            rd(3'(p), d);
            chk("R1 reset word", d, 32'h000C0000);
        end
        chk("R1 pad_oe", 32'(pad_oe), 32'h0);
        chk("R1 pull_en", 32'(pad_pull_en), 32'hF);
        chk("R1 pull_up", 32'(pad_pull_up), 32'h0);
        chk("R1 mode_err", 32'(mode_err), 32'h0);
        chk("R9 dsis f2,f5,f7", {29'h0, func_in[7], func_in[5], func_in[2]}, 32'h5);
        // pad_in = 0101: f0,f1,f4 from pin0 (1), f3 from pin2 (1), f6 from pin3 (0)
        chk("R10 shared f0 f1 f3 f4 f6",
            {27'h0, func_in[6], func_in[4], func_in[3], func_in[1], func_in[0]}, 32'h0F);
    endtask

    task automatic t_oor();
        logic [31:0] d;
        wr(3'd5, 32'h0003_0001);
        rd(3'd5, d);
        chk("R11 oor read", d, 32'h0);
        for (int p = 0; p < 4; p++) begin
            rd(3'(p), d);
            chk("R11 words untouched", d, 32'h000C0000);
        end
    endtask

    task automatic t_write_timing();
        logic [31:0] d;
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h1;
        #1;
        chk("R2 before edge", reg_rdata, 32'h000C0000);
        @(negedge clk);
        reg_we = 1'b0;
        rd(3'd0, d);
        chk("R2 after edge", d, 32'h000C0001);
    endtask

    task automatic t_out_mux();
        func_out = 8'h01; func_oe = 8'h01; settle();
        chk("R6 pin0 f0 drive", {30'h0, pad_oe[0], pad_out[0]}, 32'h3);
        func_oe = 8'h00; settle();
        chk("R6 pin0 f0 oe low", 32'(pad_oe[0]), 32'h0);
        wr(3'd0, 32'h3);
        func_out = 8'h10; func_oe = 8'h10; settle();
        chk("R6 pin0 f4 drive", {30'h0, pad_oe[0], pad_out[0]}, 32'h3);
        func_out = 8'hEF; func_oe = 8'hEF; settle();
        chk("R6 pin0 ignores other funcs", {30'h0, pad_oe[0], pad_out[0]}, 32'h0);
        wr(3'd0, 32'h0);
        func_out = 8'hFF; func_oe = 8'hFF; settle();
        chk("R5 pin0 idle", {30'h0, pad_oe[0], pad_out[0]}, 32'h0);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        wr(3'd1, 32'hFFFF_FF02);
        rd(3'd1, d);
        chk("R3 all ones write", d, 32'h000F0002);
        wr(3'd1, 32'h0000_0002);
        rd(3'd1, d);
        chk("R3 rsv reads one", d, 32'h000C0002);
    endtask

    task automatic t_pull();
        wr(3'd1, 32'h0002_0002);
        chk("R4 pull up enabled", {30'h0, pad_pull_en[1], pad_pull_up[1]}, 32'h3);
        wr(3'd1, 32'h0001_0002);
        chk("R4 pull disabled down", {30'h0, pad_pull_en[1], pad_pull_up[1]}, 32'h0);
    endtask

    task automatic t_dsis_select();
        // pin1 selector 2 = f2 (from t_pull)
        pad_in = 4'b0000; settle();
        chk("R8 f2 from pin1 low", 32'(func_in[2]), 32'h0);
        pad_in = 4'b0010; settle();
        chk("R8 f2 from pin1 high", 32'(func_in[2]), 32'h1);
        pad_in = 4'b0100; wr(3'd2, 32'h3);
        chk("R8 f5 from pin2", 32'(func_in[5]), 32'h1);
        wr(3'd2, 32'h0);
        chk("R9 f5 const after release", 32'(func_in[5]), 32'h0);
    endtask

    task automatic t_multi();
        wr(3'd2, 32'h1);      // pin2 -> f2, pin1 still -> f2
        pad_in = 4'b0100; settle();
        chk("R8 lowest pin wins 0", 32'(func_in[2]), 32'h0);
        pad_in = 4'b0010; settle();
        chk("R8 lowest pin wins 1", 32'(func_in[2]), 32'h1);
        wr(3'd1, 32'h0);
        chk("R8 pin2 takes over", 32'(func_in[2]), 32'h0);
        wr(3'd2, 32'h0);
        chk("R9 f2 const", 32'(func_in[2]), 32'h1);
    endtask

    task automatic t_home();
        pad_in = 4'b0100; settle();
        chk("R10 f3 from pin2", 32'(func_in[3]), 32'h1);
        wr(3'd3, 32'h1);      // pin3 -> f3
        chk("R8 f3 from pin3", 32'(func_in[3]), 32'h0);
        wr(3'd3, 32'h0);
        chk("R10 f3 back to pin2", 32'(func_in[3]), 32'h1);
    endtask

    task automatic t_illegal();
        func_oe = 8'hFF; func_out = 8'hFF;
        wr(3'd1, 32'h3);      // empty entry
        chk("R7 empty entry tristate", {30'h0, pad_oe[1], pad_out[1]}, 32'h0);
        @(negedge clk); #1;
        chk("R7 err pin1 set", 32'(mode_err), 32'h2);
        wr(3'd1, 32'h1);
        @(negedge clk); #1;
        chk("R7 err pin1 sticky", 32'(mode_err), 32'h2);
        chk("R6 pin1 legal again", {30'h0, pad_oe[1], pad_out[1]}, 32'h3);
        wr(3'd3, 32'h40);     // beyond table
        chk("R7 beyond table tristate", 32'(pad_oe[3]), 32'h0);
        @(negedge clk); #1;
        chk("R7 err pin3 set", 32'(mode_err), 32'hA);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_oor();
        t_write_timing();
        t_out_mux();
        t_reserved();
        t_pull();
        t_dsis_select();
        t_multi();
        t_home();
        t_illegal();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule